// File: doc/BRIEF.md
# Received packet link forwarder

This block sits between the deserializer of a serial-bus physical layer and the parallel link-controller interface. The deserializer supplies a start pulse carrying the packet speed, then a stream of data words qualified by a valid flag, then an end pulse. The block presents the packet to the link on a two-bit control code and four data lanes. It first shows the receive code with every data lane high for as long as the first data word is still missing. It then spends one cycle on a speed code that lies outside the packet CRC, and then passes the data words in order, one per cycle. When the packet has drained it puts the interface back to idle.

At the slow speed only two of the four lanes carry data and the other two are held low. At the fast speed all four lanes carry data. When no packet is being received, the block can also drive a short status transfer. A packet start always wins over a status transfer, and a status transfer that is already running is cut off.

The controller has five states: IDLE, STATUS, PREAMBLE, SPEED and DATA. Its transitions are as follows.
- IDLE or STATUS to PREAMBLE when a start pulse arrives (go_rx).
- IDLE or STATUS to STATUS when a status request is present and no start pulse is (go_status).
- STATUS to IDLE when neither a request nor a start pulse is present (status_done).
- PREAMBLE to SPEED when the first valid word or the end pulse is sampled (first_word).
- SPEED to DATA when words are buffered or arriving (have_data).
- SPEED to IDLE when the packet ended with no data (empty_done).
- DATA to IDLE when the packet has ended and the last buffered word is leaving (drained).

Top module: `fwd_rx_link`

## Requirements
- R1: ctl_out is 2'b00 for idle, 2'b01 for status and 2'b10 for receive. It is never 2'b11, and it stays 2'b10 for every cycle of a packet.
- R2: A pkt_start sampled in IDLE or STATUS gives ctl_out=2'b10 with d_out=4'b1111 in the following cycle. This preamble lasts for the start cycle plus one cycle for each edge that passes before the first valid word is sampled.
- R3: The cycle after the preamble carries the speed code. d_out=4'b0000 when pkt_speed was 0 (slow) at the start edge. d_out=4'b0010 when pkt_speed was 1 (fast). Bit i of d_out is data lane i.
- R4: Data words appear in arrival order, one per cycle, two cycles after the edge that sampled them. At the slow speed d_out[1:0] carries rx_word[1:0] and d_out[3:2] is 0. At the fast speed d_out carries all four bits of rx_word.
- R5: The cycle after the last data word is idle. This holds whether pkt_end arrives with the last word, one edge later or two edges later.
- R6: A packet whose pkt_end comes with no data word still gives the preamble and one speed-code cycle, followed by idle.
- R7: During reset and whenever idle, ctl_out=2'b00 and d_out=4'b0000.
- R8: A stat_req sampled in IDLE or STATUS without pkt_start gives ctl_out=2'b01 with d_out={2'b00, stat_bits} in the next cycle. Once stat_req is low, the block returns to idle.
- R9: A pkt_start sampled during STATUS preempts it, and the next cycle is the receive preamble.
- R10: pkt_start and stat_req sampled while a packet is in progress have no effect on ctl_out or d_out. This includes the speed that the ignored pkt_start carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_start | input | 1 | One-cycle pulse marking the start of an incoming packet |
| pkt_speed | input | 1 | Packet speed with pkt_start: 0 slow (two lanes), 1 fast (four lanes) |
| dat_valid | input | 1 | rx_word holds a packet data word |
| rx_word | input | 4 | Deserialized data word, of which bits [1:0] are used at the slow speed |
| pkt_end | input | 1 | One-cycle pulse marking the end of the packet |
| stat_req | input | 1 | Request for a status transfer |
| stat_bits | input | 2 | Status bits shown during a status transfer |
| ctl_out | output | 2 | Control code to the link |
| d_out | output | 4 | Data lanes to the link |

## Verification
The bench sweeps both speeds, preamble waits of zero to two cycles, packet lengths of zero to six words, and pkt_end arriving with the last word or one or two edges after it. It compares every output cycle against a trace computed from the requirements. The waits separate a preamble that correctly stretches from one that has a fixed length. The end offsets show whether the last word is lost, or an extra cycle added, when the end pulse comes early or late. The fast and slow runs distinguish correct lane masking and speed codes from swapped ones. Extra runs hold stat_req high during the packet or pulse pkt_start with the opposite speed in the middle of it, to show that both are ignored. All four status values, and preemption of a running status transfer, are also tried.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_STATUS   = 3'd1,
        ST_PREAMBLE = 3'd2,
        ST_SPEED    = 3'd3,
        ST_DATA     = 3'd4
    } fwd_state_t;

    localparam int          LANES        = 4;
    localparam int          NARROW_LANES = 2;
    localparam int          STAT_W       = 2;

    localparam logic [1:0]  CTL_IDLE     = 2'b00;
    localparam logic [1:0]  CTL_STATUS   = 2'b01;
    localparam logic [1:0]  CTL_RECEIVE  = 2'b10;

    localparam logic [LANES-1:0] D_QUIET     = '0;
    localparam logic [LANES-1:0] D_PREAMBLE  = '1;
    localparam logic [LANES-1:0] D_SPD_SLOW  = 4'b0000;
    localparam logic [LANES-1:0] D_SPD_FAST  = 4'b0010;

    function automatic logic [LANES-1:0] speed_code(input logic fast);
        return fast ? D_SPD_FAST : D_SPD_SLOW;
    endfunction

endpackage

// File: rtl/fwd_fifo.sv
`timescale 1ns/1ps
module fwd_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/fwd_ctrl.sv
`timescale 1ns/1ps
module fwd_ctrl
    import fwd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              pkt_speed,
    input  logic              pkt_end,
    input  logic              dat_valid,
    input  logic              stat_req,
    input  logic [STAT_W-1:0] stat_bits,
    input  logic [CNT_W-1:0]  fifo_count,
    output fwd_state_t        state,
    output logic              speed_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              push,
    output logic              pop
);

    fwd_state_t state_nx;
    logic       end_seen;
    logic       in_rx;
    logic       ended;
    logic       drained;
    logic       buf_empty;

    assign in_rx     = (state == ST_PREAMBLE) || (state == ST_SPEED) || (state == ST_DATA);
    assign push      = in_rx && dat_valid && !end_seen;
    assign pop       = (state == ST_DATA) && (fifo_count != '0);
    assign ended     = end_seen || pkt_end;
    assign buf_empty = (fifo_count == '0);
    assign drained   = (fifo_count <= CNT_W'(1)) && !push;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // per-packet and per-status context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_q  <= 1'b0;
            stat_q   <= '0;
            end_seen <= 1'b0;
        end else begin
            if (!in_rx) begin
                end_seen <= 1'b0;
                if (pkt_start) begin
                    speed_q <= pkt_speed;
                end else if (stat_req) begin
                    stat_q <= stat_bits;
                end
            end else if (pkt_end) begin
                end_seen <= 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_STATUS: begin
                if (pkt_start) begin
                    state_nx = ST_PREAMBLE;          // go_rx
                end else if (stat_req) begin
                    state_nx = ST_STATUS;            // go_status
                end else begin
                    state_nx = ST_IDLE;              // status_done
                end
            end
            ST_PREAMBLE: begin
                if (dat_valid || pkt_end) begin
                    state_nx = ST_SPEED;             // first_word
                end
            end
            ST_SPEED: begin
                if (buf_empty && !push && ended) begin
                    state_nx = ST_IDLE;              // empty_done
                end else begin
                    state_nx = ST_DATA;              // have_data
                end
            end
            ST_DATA: begin
                if (ended && drained) begin
                    state_nx = ST_IDLE;              // drained
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/fwd_outmux.sv
`timescale 1ns/1ps
module fwd_outmux
    import fwd_pkg::*;
(
    input  fwd_state_t        state,
    input  logic              speed_q,
    input  logic [STAT_W-1:0] stat_q,
    input  logic [LANES-1:0]  head,
    output logic [1:0]        ctl_out,
    output logic [LANES-1:0]  d_out
);

    logic [LANES-1:0] lanes;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < NARROW_LANES) begin : g_narrow
            assign lanes[i] = head[i];
        end else begin : g_wide
            assign lanes[i] = head[i] & speed_q;
        end
    end

    always_comb begin
        ctl_out = CTL_IDLE;
        d_out   = D_QUIET;
        unique case (state)
            ST_IDLE: begin
                ctl_out = CTL_IDLE;
                d_out   = D_QUIET;
            end
            ST_STATUS: begin
                ctl_out = CTL_STATUS;
                d_out   = {{(LANES-STAT_W){1'b0}}, stat_q};
            end
            ST_PREAMBLE: begin
                ctl_out = CTL_RECEIVE;
                d_out   = D_PREAMBLE;
            end
            ST_SPEED: begin
                ctl_out = CTL_RECEIVE;
                d_out   = speed_code(speed_q);
            end
            ST_DATA: begin
                ctl_out = CTL_RECEIVE;
                d_out   = lanes;
            end
            default: begin
                ctl_out = CTL_IDLE;
                d_out   = D_QUIET;
            end
        endcase
    end

endmodule

// File: rtl/fwd_rx_link.sv
`timescale 1ns/1ps
module fwd_rx_link
    import fwd_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pkt_start,
    input  logic       pkt_speed,
    input  logic       dat_valid,
    input  logic [3:0] rx_word,
    input  logic       pkt_end,
    input  logic       stat_req,
    input  logic [1:0] stat_bits,
    output logic [1:0] ctl_out,
    output logic [3:0] d_out
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    fwd_state_t        state;
    logic              speed_q;
    logic [STAT_W-1:0] stat_q;
    logic              push;
    logic              pop;
    logic [CNT_W-1:0]  fifo_count;
    logic [LANES-1:0]  head;

    fwd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .pkt_speed  (pkt_speed),
        .pkt_end    (pkt_end),
        .dat_valid  (dat_valid),
        .stat_req   (stat_req),
        .stat_bits  (stat_bits),
        .fifo_count (fifo_count),
        .state      (state),
        .speed_q    (speed_q),
        .stat_q     (stat_q),
        .push       (push),
        .pop        (pop)
    );

    fwd_fifo #(.WIDTH(LANES), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wr_data (rx_word),
        .pop     (pop),
        .rd_data (head),
        .count   (fifo_count)
    );

    fwd_outmux u_out (
        .state   (state),
        .speed_q (speed_q),
        .stat_q  (stat_q),
        .head    (head),
        .ctl_out (ctl_out),
        .d_out   (d_out)
    );

endmodule

// File: rtl/fwd_rx_link_chk.sv
`timescale 1ns/1ps
module fwd_rx_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pkt_start,
    input logic       pkt_speed,
    input logic [1:0] ctl_out,
    input logic [3:0] d_out
);

    logic rx_now;
    logic prev_rx;
    logic spd_q;
    logic pre_q;
    logic dat_q;

    assign rx_now = (ctl_out == 2'b10);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_rx <= 1'b0;
            spd_q   <= 1'b0;
            pre_q   <= 1'b0;
            dat_q   <= 1'b0;
        end else begin
            prev_rx <= rx_now;
            if (pkt_start && !rx_now) begin
                spd_q <= pkt_speed;
            end
            pre_q <= rx_now && (d_out == 4'hF) && (pre_q || !prev_rx);
            dat_q <= rx_now && (dat_q || (pre_q && d_out != 4'hF));
        end
    end

    assert_ctl_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_out != 2'b11);

    assert_preamble_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !rx_now) |=> (ctl_out == 2'b10 && d_out == 4'hF));

    assert_speed_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q && rx_now && d_out != 4'hF) |-> (d_out == (spd_q ? 4'b0010 : 4'b0000)));

    assert_slow_lanes_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_q && rx_now && !spd_q) |-> (d_out[3:2] == 2'b00));

    assert_rx_exit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_rx && !rx_now) |-> (ctl_out == 2'b00));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out == 2'b00) |-> (d_out == 4'h0));

    assert_preempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && ctl_out == 2'b01) |=> rx_now);

endmodule

bind fwd_rx_link fwd_rx_link_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .pkt_speed (pkt_speed),
    .ctl_out   (ctl_out),
    .d_out     (d_out)
);

// File: tb/sim_fwd_rx_link.sv
`timescale 1ns/1ps
module sim_fwd_rx_link;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 1'b0;
    logic       pkt_speed = 1'b0;
    logic       dat_valid = 1'b0;
    logic [3:0] rx_word = 4'h0;
    logic       pkt_end = 1'b0;
    logic       stat_req = 1'b0;
    logic [1:0] stat_bits = 2'b00;
    logic [1:0] ctl_out;
    logic [3:0] d_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    fwd_rx_link u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .pkt_speed (pkt_speed),
        .dat_valid (dat_valid),
        .rx_word   (rx_word),
        .pkt_end   (pkt_end),
        .stat_req  (stat_req),
        .stat_bits (stat_bits),
        .ctl_out   (ctl_out),
        .d_out     (d_out)
    );

    task automatic check(input string req, input logic [1:0] ec, input logic [3:0] ed);
        n_checks++;
        if (ctl_out !== ec || d_out !== ed) begin
            n_fail++;
            $display("FAIL %s: ctl=%b d=%b expected ctl=%b d=%b at %0t",
                     req, ctl_out, d_out, ec, ed, $time);
        end
    endtask

    function automatic logic [3:0] word_of(input int base, input int i);
        return 4'((base * 7 + i * 5 + 3) % 16);
    endfunction

    // mode 0 plain, 1 stat_req held during packet, 2 stray start mid-packet
    task automatic run_pkt(input logic spd, input int w, input int len,
                           input int dly, input int mode, input int base);
        int k    = 1 + w;
        int endc = (len == 0) ? k : k + len - 1 + dly;
        int last = w + 2 + len;
        for (int c = 0; c <= last + 1; c++) begin
            @(negedge clk);
            if (c >= 1) begin
                int j = c - 1;
                if (j <= w)
                    check("R2 preamble", 2'b10, 4'hF);
                else if (j == w + 1)
                    check(len == 0 ? "R6 empty speed code" : "R3 speed code",
                          2'b10, spd ? 4'b0010 : 4'b0000);
                else if (j <= w + 1 + len)
                    check(mode == 0 ? "R4 data" : "R10 ignored mid-packet",
                          2'b10, word_of(base, j - w - 2) & (spd ? 4'hF : 4'h3));
                else
                    check(len == 0 ? "R6 empty end" : "R5 end to idle", 2'b00, 4'h0);
            end
            pkt_start = (c == 0) || (mode == 2 && c == k);
            pkt_speed = (c == 0) ? spd : ~spd;
            dat_valid = (c >= k) && (c < k + len);
            rx_word   = dat_valid ? word_of(base, c - k) : 4'hA;
            pkt_end   = (c == endc);
            stat_req  = (mode == 1) && (c >= 1) && (c <= last);
            stat_bits = 2'(base);
        end
        pkt_start = 1'b0;
        dat_valid = 1'b0;
        pkt_end   = 1'b0;
        stat_req  = 1'b0;
        @(negedge clk);
        check("R7 idle after packet", 2'b00, 4'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int base = 0;
        repeat (3) begin
            @(negedge clk);
            check("R7 reset", 2'b00, 4'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle after reset", 2'b00, 4'h0);

        // R8 status transfers for every status value
        for (int b = 0; b < 4; b++) begin
            stat_req  = 1'b1;
            stat_bits = 2'(b);
            @(negedge clk);
            check("R8 status", 2'b01, {2'b00, 2'(b)});
            stat_bits = 2'(3 - b);
            @(negedge clk);
            check("R8 status update", 2'b01, {2'b00, 2'(3 - b)});
            stat_req = 1'b0;
            @(negedge clk);
            check("R8 status release", 2'b00, 4'h0);
        end

        // R9 preemption of a running status transfer
        for (int s = 0; s < 2; s++) begin
            stat_req  = 1'b1;
            stat_bits = 2'b11;
            @(negedge clk);
            check("R8 status before preempt", 2'b01, 4'b0011);
            pkt_start = 1'b1;
            pkt_speed = s[0];
            @(negedge clk);
            check("R9 preempt to preamble", 2'b10, 4'hF);
            pkt_start = 1'b0;
            stat_req  = 1'b0;
            pkt_end   = 1'b1;
            @(negedge clk);
            check("R6 preempted empty speed code", 2'b10, s[0] ? 4'b0010 : 4'b0000);
            pkt_end = 1'b0;
            @(negedge clk);
            check("R6 preempted empty idle", 2'b00, 4'h0);
        end

        // main sweep
        for (int sp = 0; sp < 2; sp++) begin
            for (int w = 0; w < 3; w++) begin
                for (int len = 0; len <= 6; len++) begin
                    for (int dly = 0; dly < 3; dly++) begin
                        if (len == 0 && dly > 0) continue;
                        run_pkt(sp[0], w, len, dly, (len + w + dly) % 3, base);
                        base++;
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule